// File: doc/BRIEF.md
# Digital Echo Delay Line

This block makes a single-channel echo from signed audio samples. On each sample-rate strobe it adds the two microphone samples to form the echo input. It fetches the sample stored a chosen number of strobes earlier from a circular buffer in on-chip storage. It writes the input back into the buffer, together with an attenuated copy of the delayed sample, so that the echo repeats and decays. It also drives an echo output, which is the delayed sample scaled by a volume setting.

Three static 3-bit codes set the block's behaviour: a delay code, an echo volume code and a feedback code. All gains are unsigned multipliers with 8 fractional bits (256 is unity). Each product is truncated toward zero, and every sum is clipped to the 8-bit signed sample range. The buffer holds 2048 samples. At a 10.24 kHz strobe rate the delay taps run from 75 ms to 200 ms.

Top module: `echo_delay_line`

## Requirements
- R1: While reset is held, and until the first strobe after it, echo_out is 0.
- R2: With a delay code from 1 to 6, the sample read on strobe n is the value written on strobe n-D. D is 768 for code 1 and rises by 256 per code, so code 2 gives 1024, code 3 gives 1280, code 4 gives 1536, code 5 gives 1792 and code 6 gives 2048.
- R3: Delay codes 0 and 7 switch the echo off. The output is then 0, no feedback is added, and the mic sum is still written into the buffer on every strobe, so it can be read once a delay is selected later.
- R4: The echo volume code picks a multiplier for the delayed sample: 0→256, 1→203, 2→161, 3→128, 4→91, 5→64, 6→46, 7→0 (muted).
- R5: The feedback code picks the multiplier applied to the delayed sample before it is added to the write value: 0→203, 1→161, 2→128, 3→102. Codes 4 to 7 add no feedback.
- R6: Each scaled value equals sample×gain/256, truncated toward zero. For example, -77 at multiplier 203 gives -61.
- R7: The value written equals mic_a + mic_b + feedback, clipped to the range -128 to 127.
- R8: echo_out takes its new value on the first rising clock edge at which strobe is high, and it holds its value on every edge at which strobe is low.
- R9: Each strobe performs exactly one read and one write, and the buffer position advances by one per strobe. Clock cycles without a strobe change neither the position nor the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Sample-rate strobe, one cycle wide |
| mic_a | input | 8 | First microphone sample, signed |
| mic_b | input | 8 | Second microphone sample, signed |
| dly_code | input | 3 | Delay tap selection |
| vol_code | input | 3 | Echo output volume selection |
| fb_code | input | 3 | Feedback amount selection |
| echo_out | output | 8 | Scaled delayed sample, signed |

## Verification
The echo output is due exactly one clock edge after a strobe. The bench raises strobe at a falling edge and samples echo_out at the next falling edge, once the rising edge that stores it has passed. During the idle cycles after a strobe it samples the output again to confirm it holds. A value written on strobe n is due on the output at strobe n+D, counted in strobes and never in clock cycles. The bench therefore keeps a history indexed by strobe count, and it inserts idle gaps of varying length to show that clock cycles without a strobe do not move the tap.

// File: rtl/echo_pkg.sv
package echo_pkg;
    localparam int SAMPLE_W = 8;
    localparam int GAIN_W   = 9;
    localparam int FRAC_W   = 8;
    localparam int CODE_W   = 3;
    localparam int DEPTH    = 2048;
    localparam int ADDR_W   = $clog2(DEPTH);
    localparam int TAP_BASE = 768;
    localparam int TAP_STEP = 256;

    typedef logic signed [SAMPLE_W-1:0]      sample_t;
    typedef logic signed [SAMPLE_W+1:0]      wide_t;
    typedef logic signed [SAMPLE_W+GAIN_W:0] prod_t;
    typedef logic [GAIN_W-1:0]               gain_t;
    typedef logic [CODE_W-1:0]               code_t;
    typedef logic [ADDR_W-1:0]               addr_t;

    typedef struct packed {
        logic              on;
        logic [ADDR_W:0]   len;
    } tap_t;

    localparam wide_t SAT_HI = wide_t'((1 << (SAMPLE_W-1)) - 1);
    localparam wide_t SAT_LO = wide_t'(-(1 << (SAMPLE_W-1)));
    localparam prod_t RND    = prod_t'((1 << FRAC_W) - 1);

    function automatic tap_t decode_tap(code_t c);
        tap_t t;
        t.on  = (c != '0) && (c != '1);
        t.len = t.on ? (ADDR_W+1)'(TAP_BASE + (int'(c) - 1) * TAP_STEP) : '0;
        return t;
    endfunction

    function automatic gain_t echo_gain(code_t c);
        case (c)
            3'd0:    return gain_t'(256);
            3'd1:    return gain_t'(203);
            3'd2:    return gain_t'(161);
            3'd3:    return gain_t'(128);
            3'd4:    return gain_t'(91);
            3'd5:    return gain_t'(64);
            3'd6:    return gain_t'(46);
            default: return gain_t'(0);
        endcase
    endfunction

    function automatic gain_t fb_gain(code_t c);
        case (c)
            3'd0:    return gain_t'(203);
            3'd1:    return gain_t'(161);
            3'd2:    return gain_t'(128);
            3'd3:    return gain_t'(102);
            default: return gain_t'(0);
        endcase
    endfunction

    function automatic wide_t scale(sample_t s, gain_t g);
        prod_t p;
        p = prod_t'(s) * prod_t'($signed({1'b0, g}));
        if (p < 0) p = p + RND;
        return wide_t'(p >>> FRAC_W);
    endfunction

    function automatic sample_t clip(wide_t v);
        if (v > SAT_HI) return sample_t'(SAT_HI);
        if (v < SAT_LO) return sample_t'(SAT_LO);
        return sample_t'(v);
    endfunction
endpackage

// File: rtl/echo_tap_ctrl.sv
module echo_tap_ctrl
    import echo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  strobe,
    input  code_t dly_code,
    output addr_t wr_ptr,
    output addr_t rd_addr,
    output logic  tap_on
);
    tap_t tap;

    always_comb begin
        tap     = decode_tap(dly_code);
        tap_on  = tap.on;
        rd_addr = wr_ptr - tap.len[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)         wr_ptr <= '0;
        else if (strobe) wr_ptr <= wr_ptr + 1'b1;
    end
endmodule

// File: rtl/echo_store.sv
module echo_store
    import echo_pkg::*;
(
    input  logic    clk,
    input  logic    we,
    input  addr_t   wr_addr,
    input  sample_t wr_data,
    input  addr_t   rd_addr,
    output sample_t rd_data
);
    sample_t mem [DEPTH];

    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (we) mem[wr_addr] <= wr_data;
    end
endmodule

// File: rtl/echo_mix.sv
module echo_mix
    import echo_pkg::*;
(
    input  sample_t rd_sample,
    input  sample_t mic_a,
    input  sample_t mic_b,
    input  logic    tap_on,
    input  code_t   vol_code,
    input  code_t   fb_code,
    output sample_t wr_sample,
    output sample_t out_next
);
    wide_t fb_term;
    wide_t sum;

    always_comb begin
        fb_term   = tap_on ? scale(rd_sample, fb_gain(fb_code)) : '0;
        sum       = wide_t'(mic_a) + wide_t'(mic_b) + fb_term;
        wr_sample = clip(sum);
        out_next  = tap_on ? clip(scale(rd_sample, echo_gain(vol_code))) : '0;
    end
endmodule

// File: rtl/echo_delay_line.sv
module echo_delay_line
    import echo_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       strobe,
    input  logic signed [SAMPLE_W-1:0] mic_a,
    input  logic signed [SAMPLE_W-1:0] mic_b,
    input  logic [CODE_W-1:0]          dly_code,
    input  logic [CODE_W-1:0]          vol_code,
    input  logic [CODE_W-1:0]          fb_code,
    output logic signed [SAMPLE_W-1:0] echo_out
);
    addr_t   wr_ptr;
    addr_t   rd_addr;
    logic    tap_on;
    sample_t rd_sample;
    sample_t wr_sample;
    sample_t out_next;

    echo_tap_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .strobe   (strobe),
        .dly_code (dly_code),
        .wr_ptr   (wr_ptr),
        .rd_addr  (rd_addr),
        .tap_on   (tap_on)
    );

    echo_store u_store (
        .clk     (clk),
        .we      (strobe),
        .wr_addr (wr_ptr),
        .wr_data (wr_sample),
        .rd_addr (rd_addr),
        .rd_data (rd_sample)
    );

    echo_mix u_mix (
        .rd_sample (rd_sample),
        .mic_a     (mic_a),
        .mic_b     (mic_b),
        .tap_on    (tap_on),
        .vol_code  (vol_code),
        .fb_code   (fb_code),
        .wr_sample (wr_sample),
        .out_next  (out_next)
    );

    always_ff @(posedge clk) begin
        if (rst)         echo_out <= '0;
        else if (strobe) echo_out <= out_next;
    end
endmodule

// File: rtl/echo_delay_line_chk.sv
module echo_delay_line_chk
    import echo_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       strobe,
    input logic [CODE_W-1:0]          dly_code,
    input logic [CODE_W-1:0]          vol_code,
    input logic signed [SAMPLE_W-1:0] echo_out,
    input logic [ADDR_W-1:0]          ptr
);
    // R1: output cleared by reset
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> echo_out == '0);

    // R8: no strobe, no output change
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(echo_out));

    // R3: off codes give a silent output
    a_r3_off_silent: assert property (@(posedge clk) disable iff (rst)
        (strobe && (dly_code == 3'd0 || dly_code == 3'd7)) |=> echo_out == '0);

    // R4: mute code gives a silent output
    a_r4_mute: assert property (@(posedge clk) disable iff (rst)
        (strobe && vol_code == 3'd7) |=> echo_out == '0);

    // R9: position advances once per strobe
    a_r9_advance: assert property (@(posedge clk) disable iff (rst)
        strobe |=> ptr == ADDR_W'($past(ptr) + 1'b1));

    // R9: position frozen without a strobe
    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(ptr));
endmodule

bind echo_delay_line echo_delay_line_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .dly_code (dly_code),
    .vol_code (vol_code),
    .echo_out (echo_out),
    .ptr      (wr_ptr)
);

// File: tb/sim_echo_delay_line.sv
module sim_echo_delay_line;
    localparam int CLK_PERIOD = 10;
    localparam int HIST_N     = 32768;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              strobe = 1'b0;
    logic signed [7:0] mic_a = '0;
    logic signed [7:0] mic_b = '0;
    logic [2:0]        dly_code = 3'd0;
    logic [2:0]        vol_code = 3'd0;
    logic [2:0]        fb_code  = 3'd4;
    logic signed [7:0] echo_out;

    int tests = 0;
    int fails = 0;
    int n = 0;
    int hist [HIST_N];
    bit done = 1'b0;

    int vt [8] = '{256, 203, 161, 128, 91, 64, 46, 0};
    int ft [8] = '{203, 161, 128, 102, 0, 0, 0, 0};

    always #(CLK_PERIOD/2) clk = ~clk;

    echo_delay_line u0 (
        .clk(clk), .rst(rst), .strobe(strobe), .mic_a(mic_a), .mic_b(mic_b),
        .dly_code(dly_code), .vol_code(vol_code), .fb_code(fb_code), .echo_out(echo_out)
    );

    function automatic int bscale(int x, int g);
        int p = x * g;
        if (p < 0) return -((-p) / 256);
        return p / 256;
    endfunction

    function automatic int bclip(int v);
        if (v > 127)  return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    task automatic check(int act, int exp, string req);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: echo_out=%0d expected=%0d (strobe %0d)", req, act, exp, n);
        end
    endtask

    // one strobe with model update; gap idle cycles follow with a hold check
    task automatic pulse(int a, int b, int gap, string req, output int exp);
        int d, x, fb, on;
        d  = int'(dly_code);
        on = (d >= 1 && d <= 6);
        x  = 0;
        if (on) begin
            int lag = 768 + (d - 1) * 256;
            if (n >= lag) x = hist[n - lag];
        end
        fb  = (on != 0) ? bscale(x, ft[fb_code]) : 0;
        hist[n] = bclip(a + b + fb);
        exp = (on != 0) ? bclip(bscale(x, vt[vol_code])) : 0;
        @(negedge clk);
        mic_a = 8'(a); mic_b = 8'(b); strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        n++;
        check(int'(echo_out), exp, req);
        repeat (gap) @(negedge clk);
        if (gap > 0) check(int'(echo_out), exp, "R8 hold");
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(int'(echo_out), 0, "R1 during reset");
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(int'(echo_out), 0, "R1 after reset");
    endtask

    task automatic t_prime;
        int e;
        dly_code = 3'd0;
        for (int i = 0; i < 2048; i++) pulse(0, 0, 0, "R3 prime", e);
    endtask

    task automatic t_off_writes;
        int e;
        dly_code = 3'd7;
        for (int i = 0; i < 40; i++) pulse(i * 3 - 60, 5, i % 3, "R3 off", e);
        dly_code = 3'd0;
        for (int i = 0; i < 40; i++) pulse(60 - i * 2, -7, 0, "R3 off", e);
        dly_code = 3'd1; fb_code = 3'd4; vol_code = 3'd0;
        for (int i = 0; i < 768; i++) pulse(0, 0, 0, "R3 seamless", e);
    endtask

    task automatic t_taps;
        int e;
        fb_code = 3'd4; vol_code = 3'd0;
        for (int c = 1; c <= 6; c++) begin
            int lag = 768 + (c - 1) * 256;
            dly_code = 3'(c);
            for (int i = 0; i < lag; i++) pulse(0, 0, 0, "R2 flush", e);
            pulse(100, 0, 0, "R2 tap", e);
            for (int i = 0; i < lag - 2; i++) pulse(0, 0, 0, "R2 tap", e);
            pulse(0, 0, 0, "R2 before", e);
            check(e, 0, "R2 before");
            pulse(0, 0, 0, "R2 exact", e);
            check(int'(echo_out), 100, "R2 exact delay");
        end
    endtask

    task automatic t_gains;
        int e;
        dly_code = 3'd1; fb_code = 3'd4; vol_code = 3'd0;
        for (int i = 0; i < 768; i++) pulse((i % 2 == 0) ? (i % 128) - 64 : -77, 50, 0, "R4 fill", e);
        for (int i = 0; i < 768; i++) begin
            vol_code = 3'(i % 8);
            pulse(0, 0, i % 2, "R4 volume", e);
        end
        vol_code = 3'd0;
        for (int i = 0; i < 768; i++) begin
            fb_code = 3'(i % 8);
            pulse(i % 100, -30, 0, "R5 feedback", e);
        end
        fb_code = 3'd4;
        for (int i = 0; i < 768; i++) pulse(0, 0, 0, "R5 readback", e);
    endtask

    task automatic t_round;
        int e;
        dly_code = 3'd1; fb_code = 3'd4; vol_code = 3'd1;
        pulse(-77, 0, 0, "R6 write", e);
        for (int i = 0; i < 767; i++) pulse(0, 0, 0, "R6 wait", e);
        pulse(0, 0, 0, "R6 read", e);
        check(int'(echo_out), -61, "R6 toward zero");
    endtask

    task automatic t_sat;
        int e;
        dly_code = 3'd1; fb_code = 3'd4; vol_code = 3'd0;
        pulse(127, 127, 0, "R7 write", e);
        pulse(-128, -128, 0, "R7 write", e);
        pulse(100, -30, 0, "R7 write", e);
        for (int i = 0; i < 765; i++) pulse(0, 0, 0, "R7 wait", e);
        pulse(0, 0, 0, "R7 high", e);
        check(int'(echo_out), 127, "R7 clip high");
        pulse(0, 0, 0, "R7 low", e);
        check(int'(echo_out), -128, "R7 clip low");
        pulse(0, 0, 0, "R7 sum", e);
        check(int'(echo_out), 70, "R7 mic sum");
    endtask

    task automatic t_gaps;
        int e;
        dly_code = 3'd1; fb_code = 3'd0; vol_code = 3'd2;
        for (int i = 0; i < 1600; i++) pulse((i * 7) % 120 - 60, 40, (i * 5) % 4, "R9 gaps", e);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_prime();
        t_off_writes();
        t_taps();
        t_gains();
        t_round();
        t_sat();
        t_gaps();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end
endmodule